// File: doc/BRIEF.md
# Maskable Interrupt Condition and Vector Unit

This unit gathers a small set of interrupt condition levels from serial channels into a status register, and filters them through a mask register that software can write but not read. When any condition that is both present and enabled is active, the unit pulls a single shared active-low interrupt request. When the processor answers with an interrupt-acknowledge cycle, the unit returns an 8-bit vector number that software has loaded into a vector register.

A CPU-side bus reaches the registers. Address 0 returns the live status on a read and loads the mask on a write. Address 1 holds the vector, which can be both read and written. A small bus-response state machine handles read and acknowledge cycles. It has three states. `ST_IDLE` leaves the data bus released. `ST_READ` drives the register at the latched address. `ST_ACK` drives the vector. The machine evaluates these rules at each clock edge, in priority order:
- `ACK_TAKE`: any state goes to `ST_ACK` when select and acknowledge are both asserted.
- `READ_TAKE`: any state goes to `ST_READ` when select and read are asserted without acknowledge.
- `RELEASE`: any state goes to `ST_IDLE` when neither case applies.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset the mask is all zeros, the vector register holds 0x0F, `irq_n` is 1, and the bus is released (`rdata_oe` = 0, `rdata` = 0).
- R2: Status bit i equals `cond[i]` as it was sampled at the previous clock edge. Bit 1 is the channel A "receive character held" condition. A read at address 0 returns the status in bits 3:0, with zeros above.
- R3: A write (`sel` and `wr` both 1) at address 0 loads `wdata[3:0]` into the mask. A later read at address 0 still returns the status and not the mask.
- R4: `irq_n` is 0 exactly when the registered status ANDed with the mask is nonzero. The status and the mask both update at the clock edge.
- R5: A write at address 1 loads any 8-bit value (0 to 255, including 64) into the vector register. A read at address 1 returns that value.
- R6: While `sel` and `iack` stay asserted, starting from the first clock edge at which both are seen, `rdata_oe` is 1 and `rdata` carries the vector.
- R7: Outside an accepted read or acknowledge (for example when `sel` is 0, or the strobe has dropped), `rdata_oe` is 0 and `rdata` is 0.
- R8: When `iack` and `rd` are both asserted with `sel`, the acknowledge response wins and the vector is driven.
- R9: Status bits are live. When a condition clears, its status bit clears at the next edge, and `irq_n` returns to 1 if no other enabled bit remains. An acknowledge does not clear anything.
- R10: While `sel` and `rd` stay asserted, starting from the first edge at which both are seen, `rdata_oe` is 1 and `rdata` carries the register at the address latched at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cond | input | 4 | per-condition event levels |
| sel | input | 1 | chip select, active high |
| wr | input | 1 | write strobe |
| rd | input | 1 | read strobe |
| addr | input | 1 | register address (0 status/mask, 1 vector) |
| wdata | input | 8 | write data |
| iack | input | 1 | interrupt-acknowledge strobe |
| rdata | output | 8 | read / vector data, 0 when released |
| rdata_oe | output | 1 | data bus drive enable |
| irq_n | output | 1 | interrupt request, active low |

## Verification
The checker enforces the following rules on every cycle:
- The bus is only driven under select together with a strobe.
- An acknowledge held across an edge drives the bus.
- The vector stays steady throughout a held acknowledge.
- The request stays high until the mask has been written and after a quiet cycle on all conditions.

The relationship between specific mask values and specific status patterns, the exact data returned, acknowledge-over-read priority, and full-range vector loads can only be shown by the bench. Its cycle-accurate reference model is compared against the design on every clock during those scenarios.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int unsigned N_COND = 4;
    localparam int unsigned DW     = 8;
    localparam logic [DW-1:0] VEC_RESET = 8'h0F;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_ACK  = 2'd2
    } bus_state_t;
endpackage

// File: rtl/irq_cond_mask.sv
module irq_cond_mask #(
    parameter int unsigned NC = 4,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NC-1:0] cond,
    input  logic          mask_we,
    input  logic [DW-1:0] wdata,
    output logic [NC-1:0] status_q,
    output logic          irq_n
);
    logic [NC-1:0] mask_q;
    logic [NC-1:0] pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= cond;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= wdata[NC-1:0];
        end
    end

    generate
        for (genvar i = 0; i < NC; i++) begin : g_pend
            assign pend[i] = status_q[i] & mask_q[i];
        end
    endgenerate

    assign irq_n = ~(|pend);
endmodule

// File: rtl/irq_vec_reg.sv
module irq_vec_reg #(
    parameter int unsigned DW = 8,
    parameter logic [DW-1:0] RST_VAL = 8'h0F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] vec_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= RST_VAL;
        end else if (we) begin
            vec_q <= wdata;
        end
    end
endmodule

// File: rtl/irq_bus_fsm.sv
module irq_bus_fsm
    import irq_vec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic rd,
    input  logic iack,
    input  logic addr,
    output logic drive_vec,
    output logic drive_reg,
    output logic addr_q
);
    bus_state_t state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_READ, ST_ACK: begin
                if (sel && iack)    state_d = ST_ACK;   // ACK_TAKE
                else if (sel && rd) state_d = ST_READ;  // READ_TAKE
                else                state_d = ST_IDLE;  // RELEASE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_READ) addr_q <= addr;
        end
    end

    always_comb begin
        drive_vec = 1'b0;
        drive_reg = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ: drive_reg = sel & rd & ~iack;
            ST_ACK:  drive_vec = sel & iack;
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irq_vec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_COND-1:0] cond,
    input  logic              sel,
    input  logic              wr,
    input  logic              rd,
    input  logic              addr,
    input  logic [DW-1:0]     wdata,
    input  logic              iack,
    output logic [DW-1:0]     rdata,
    output logic              rdata_oe,
    output logic              irq_n
);
    localparam int unsigned PAD = DW - N_COND;

    logic [N_COND-1:0] status_q;
    logic [DW-1:0]     vec_q;
    logic              drive_vec, drive_reg, addr_q;
    logic              mask_we, vec_we;

    assign mask_we = sel & wr & ~addr;
    assign vec_we  = sel & wr &  addr;

    irq_cond_mask #(.NC(N_COND), .DW(DW)) u_cm (
        .clk(clk), .rst_n(rst_n), .cond(cond), .mask_we(mask_we),
        .wdata(wdata), .status_q(status_q), .irq_n(irq_n)
    );

    irq_vec_reg #(.DW(DW), .RST_VAL(VEC_RESET)) u_vr (
        .clk(clk), .rst_n(rst_n), .we(vec_we), .wdata(wdata), .vec_q(vec_q)
    );

    irq_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .iack(iack),
        .addr(addr), .drive_vec(drive_vec), .drive_reg(drive_reg),
        .addr_q(addr_q)
    );

    always_comb begin
        rdata = '0;
        if (drive_vec)   rdata = vec_q;
        else if (drive_reg) rdata = addr_q ? vec_q : {{PAD{1'b0}}, status_q};
    end

    assign rdata_oe = drive_vec | drive_reg;
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cond,
    input logic       sel,
    input logic       wr,
    input logic       rd,
    input logic       addr,
    input logic       iack,
    input logic [7:0] rdata,
    input logic       rdata_oe,
    input logic       irq_n
);
    logic live;
    logic mask_touched;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live <= 1'b0;
            mask_touched <= 1'b0;
        end else begin
            live <= 1'b1;
            if (sel && wr && !addr) mask_touched <= 1'b1;
        end
    end

    // R7: bus driven only under select and a strobe
    p_no_stray_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> (sel && (iack || rd)));

    // R6: acknowledge held across an edge drives the bus
    p_ack_drives_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(sel && iack) && sel && iack) |-> rdata_oe);

    // R6: vector steady through a held acknowledge without writes
    p_vec_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(rdata_oe && iack && !wr) && rdata_oe && iack) |-> $stable(rdata));

    // R1: mask is zero until first written, so no request
    p_no_irq_unmasked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_touched |-> irq_n);

    // R9: all conditions quiet at previous edge -> request released
    p_quiet_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(cond) == 4'd0) |-> irq_n);
endmodule

bind irq_vector_unit irq_vector_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cond(cond), .sel(sel), .wr(wr), .rd(rd),
    .addr(addr), .iack(iack), .rdata(rdata), .rdata_oe(rdata_oe), .irq_n(irq_n)
);

// File: tb/sim_irq_vector_unit.sv
`timescale 1ns/1ps
module sim_irq_vector_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cond = '0;
    logic       sel = 0, wr = 0, rd = 0, addr = 0, iack = 0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe, irq_n;

    always #10 clk = ~clk;

    irq_vector_unit u0 (
        .clk(clk), .rst_n(rst_n), .cond(cond), .sel(sel), .wr(wr), .rd(rd),
        .addr(addr), .wdata(wdata), .iack(iack), .rdata(rdata),
        .rdata_oe(rdata_oe), .irq_n(irq_n)
    );

    int compared = 0, mismatched = 0;
    string cur_req = "R1";
    int m_status = 0, m_mask = 0, m_vec = 15, m_kind = 0, m_addr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_status = 0; m_mask = 0; m_vec = 15; m_kind = 0; m_addr = 0;
        end else begin
            m_status = int'(cond);
            if (sel && wr && !addr) m_mask = int'(wdata[3:0]);
            if (sel && wr && addr)  m_vec = int'(wdata);
            if (sel && iack)    m_kind = 2;
            else if (sel && rd) begin m_kind = 1; m_addr = int'(addr); end
            else                m_kind = 0;
        end
    end

    always begin
        @(posedge clk);
        #5;
        begin
            int e_oe, e_irq, e_data;
            e_irq = ((m_status & m_mask) != 0) ? 0 : 1;
            e_oe = ((m_kind == 2 && sel && iack) || (m_kind == 1 && sel && rd && !iack)) ? 1 : 0;
            e_data = 0;
            if (e_oe == 1) e_data = (m_kind == 2 || m_addr == 1) ? m_vec : m_status;
            compared++;
            if (int'(irq_n) != e_irq || int'(rdata_oe) != e_oe || int'(rdata) != e_data) begin
                mismatched++;
                $display("FAIL %s: irq_n=%0d oe=%0d rdata=%0d expected irq_n=%0d oe=%0d rdata=%0d",
                         cur_req, irq_n, rdata_oe, rdata, e_irq, e_oe, e_data);
            end
        end
    end

    task automatic idle(input int n);
        @(negedge clk); sel = 0; wr = 0; rd = 0; iack = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(input logic a, input logic [7:0] d);
        @(negedge clk); sel = 1; wr = 1; rd = 0; iack = 0; addr = a; wdata = d;
        @(negedge clk); sel = 0; wr = 0;
    endtask

    task automatic rreg(input logic a, input int hold);
        @(negedge clk); sel = 1; rd = 1; wr = 0; iack = 0; addr = a;
        repeat (hold) @(negedge clk);
        sel = 0; rd = 0;
    endtask

    task automatic ack(input int hold);
        @(negedge clk); sel = 1; iack = 1; rd = 0; wr = 0;
        repeat (hold) @(negedge clk);
        sel = 0; iack = 0;
    endtask

    task automatic scenario();
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1;
        rreg(1'b1, 2);                     // reset vector 0x0F
        idle(2);
        cur_req = "R2";
        cond = 4'b0010; idle(2);
        rreg(1'b0, 2);
        cond = 4'b1101; idle(1); rreg(1'b0, 1);
        cur_req = "R3";
        wreg(1'b0, 8'hF5);
        rreg(1'b0, 2);
        cur_req = "R4";
        cond = 4'b0000; idle(2);
        cond = 4'b0010; idle(2);
        wreg(1'b0, 8'h02); idle(2);
        wreg(1'b0, 8'h08); idle(2);
        cond = 4'b1000; idle(2);
        cur_req = "R9";
        cond = 4'b0000; idle(2);
        cur_req = "R5";
        wreg(1'b1, 8'd64); rreg(1'b1, 2);
        wreg(1'b1, 8'hFF); rreg(1'b1, 1);
        wreg(1'b1, 8'h00); rreg(1'b1, 1);
        wreg(1'b1, 8'd64);
        cur_req = "R6";
        cond = 4'b0010; wreg(1'b0, 8'h0F); idle(1);
        ack(4);
        cur_req = "R9";
        idle(2);                           // acknowledge cleared nothing
        cond = 4'b0000; idle(2);
        cur_req = "R7";
        @(negedge clk); sel = 0; iack = 1; rd = 1;
        repeat (3) @(negedge clk);
        iack = 0; rd = 0; idle(1);
        cur_req = "R8";
        @(negedge clk); sel = 1; iack = 1; rd = 1; addr = 0;
        repeat (3) @(negedge clk);
        iack = 0;                          // read continues
        repeat (2) @(negedge clk);
        sel = 0; rd = 0;
        cur_req = "R10";
        cond = 4'b0110; idle(1);
        rreg(1'b0, 3);
        rreg(1'b1, 3);
        idle(3);
    endtask

    initial begin
        bit timeout = 0;
        fork
            scenario();
            begin repeat (100000) @(posedge clk); timeout = 1; end
        join_any
        disable fork;
        if (timeout) begin
            mismatched++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule